// File: doc/BRIEF.md
# Branch and Skip Condition Resolver

This block settles the outcome of every conditional control-flow instruction in a small 8-bit RISC core. From the current word address, the status byte, an operation class with its 3-bit selector, a 7-bit signed offset, the register and I/O operand bytes, a compare-equal result and a flag for a two-word follower, it picks the next program-counter value. It also reports whether the branch or skip happened and how many extra cycles the pipeline must stall.

Conditional branches and skip-next-instruction forms share one resolver. A branch that is taken jumps relative to the following word. A skip that succeeds steps over a following instruction of one or two words. Every result is registered, so the outputs show the inputs that were present at the previous rising clock edge.

Top module: `bsr_resolver`

## Requirements
- R1: With op class 0 (none), the outputs one cycle later are next PC = PC + 1, taken low and stall 0.
- R2: Op class 1 (branch if flag set) is taken when status bit `sel` is 1. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, so selector 7 tests the interrupt-enable bit. A taken branch gives next PC = PC + 1 + offset and stall 1.
- R3: Op class 2 (branch if flag cleared) is taken when status bit `sel` is 0. Its next PC and stall follow the same rule as R2.
- R4: For op classes 1 and 2 with selector 4, the tested flag is N xor V (status bits 2 and 3). The stored bit 4 is ignored, so signed greater-or-equal is class 2 and signed less-than is class 1.
- R5: The offset is 7-bit two's complement and is sign-extended. All PC arithmetic wraps modulo 1024.
- R6: Whenever nothing is taken or skipped, next PC = PC + 1 and stall = 0.
- R7: Op classes 3 and 4 skip when bit `sel` of the register operand is 0 (class 3) or 1 (class 4).
- R8: Op classes 5 and 6 skip when bit `sel` of the I/O operand is 0 (class 5) or 1 (class 6).
- R9: Op class 7 skips exactly when the compare-equal input is high.
- R10: A successful skip gives next PC = PC + 2 and stall 1 when the follower is one word long. It gives PC + 3 and stall 2 when the follower is two words long.
- R11: The two-word flag has no effect on the outputs for op classes 0, 1 and 2.
- R12: While reset is asserted, next PC is 0, taken is 0 and stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 10 | Word address of the current instruction |
| status_i | input | 8 | Status byte |
| op_i | input | 3 | Operation class |
| sel_i | input | 3 | Flag selector or bit index |
| offset_i | input | 7 | Signed branch offset |
| reg_val_i | input | 8 | Register operand under test |
| io_val_i | input | 8 | I/O operand under test |
| eq_i | input | 1 | Register compare-equal result |
| two_word_i | input | 1 | Following instruction is two words long |
| next_pc_o | output | 10 | Resolved next word address |
| taken_o | output | 1 | Branch taken or skip performed |
| stall_o | output | 2 | Extra cycles to stall |

## Verification
The assertions assume that every input holds a known value at each rising edge after reset. They relate each output to the inputs of the previous edge, and they start only once one edge has passed since reset was released. The bench meets this by driving every input on the falling edge. Its sweep covers every op class and selector against all 256 status bytes, with operands, offsets, PC values and the two-word flag derived arithmetically from a running count, so all inputs stay defined throughout.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_BR_SET  = 3'd1,
    OP_BR_CLR  = 3'd2,
    OP_SKR_CLR = 3'd3,
    OP_SKR_SET = 3'd4,
    OP_SKI_CLR = 3'd5,
    OP_SKI_SET = 3'd6,
    OP_SK_EQ   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ADV_SEQ   = 2'd0,
    ADV_BR    = 2'd1,
    ADV_SKIP1 = 2'd2,
    ADV_SKIP2 = 2'd3
  } adv_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned FLAG_S = 4;
  localparam int unsigned FLAG_I = 7;
endpackage

// File: rtl/bsr_flag_sel.sv
module bsr_flag_sel #(
  parameter int unsigned SR_W  = 8,
  parameter int unsigned SEL_W = $clog2(SR_W)
) (
  input  logic [SR_W-1:0]  status_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             flag_o
);
  import bsr_pkg::*;

  logic [SR_W-1:0] eff;

  // sign slot evaluated live from N and V
  generate
    for (genvar b = 0; b < SR_W; b++) begin : g_eff
      if (b == FLAG_S) begin : g_sign
        assign eff[b] = status_i[FLAG_N] ^ status_i[FLAG_V];
      end else begin : g_raw
        assign eff[b] = status_i[b];
      end
    end
  endgenerate

  assign flag_o = eff[sel_i];
endmodule

// File: rtl/bsr_skip_test.sv
module bsr_skip_test #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
  input  bsr_pkg::op_e      op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] io_val_i,
  input  logic              eq_i,
  output logic              skip_o
);
  import bsr_pkg::*;

  logic reg_bit, io_bit;

  assign reg_bit = reg_val_i[sel_i];
  assign io_bit  = io_val_i[sel_i];

  always_comb begin
    unique case (op_i)
      OP_SKR_CLR: skip_o = ~reg_bit;
      OP_SKR_SET: skip_o = reg_bit;
      OP_SKI_CLR: skip_o = ~io_bit;
      OP_SKI_SET: skip_o = io_bit;
      OP_SK_EQ:   skip_o = eq_i;
      default:    skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsr_pc_next.sv
module bsr_pc_next #(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  bsr_pkg::adv_e    adv_i,
  output logic [PC_W-1:0]  next_pc_o
);
  import bsr_pkg::*;

  localparam int unsigned EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] step;

  assign ofs_ext = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};

  always_comb begin
    unique case (adv_i)
      ADV_BR:    step = ofs_ext + PC_W'(1);
      ADV_SKIP1: step = PC_W'(2);
      ADV_SKIP2: step = PC_W'(3);
      default:   step = PC_W'(1);
    endcase
  end

  assign next_pc_o = pc_i + step;
endmodule

// File: rtl/bsr_resolver.sv
module bsr_resolver #(
  parameter int unsigned PC_W   = 10,
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [2:0]        op_i,
  input  logic [2:0]        sel_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] io_val_i,
  input  logic              eq_i,
  input  logic              two_word_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [STL_W-1:0]  stall_o
);
  import bsr_pkg::*;

  op_e             op;
  logic            flag, skip, is_br, is_skip, br_taken, hit;
  adv_e            adv;
  logic [PC_W-1:0] pc_nx;
  logic [STL_W-1:0] stl_nx;
  logic            primed_q;

  assign op      = op_e'(op_i);
  assign is_br   = (op == OP_BR_SET) || (op == OP_BR_CLR);
  assign is_skip = (op_i >= 3'd3);

  bsr_flag_sel #(.SR_W(DATA_W)) i_flag (
    .status_i (status_i),
    .sel_i    (sel_i),
    .flag_o   (flag)
  );

  bsr_skip_test #(.DATA_W(DATA_W)) i_skip (
    .op_i      (op),
    .sel_i     (sel_i),
    .reg_val_i (reg_val_i),
    .io_val_i  (io_val_i),
    .eq_i      (eq_i),
    .skip_o    (skip)
  );

  assign br_taken = is_br && (flag ^ (op == OP_BR_CLR));
  assign hit      = br_taken || (is_skip && skip);

  always_comb begin
    if (br_taken)              adv = ADV_BR;
    else if (is_skip && skip)  adv = two_word_i ? ADV_SKIP2 : ADV_SKIP1;
    else                       adv = ADV_SEQ;
  end

  bsr_pc_next #(.PC_W(PC_W), .OFS_W(OFS_W)) i_pc (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .adv_i     (adv),
    .next_pc_o (pc_nx)
  );

  always_comb begin
    unique case (adv)
      ADV_SKIP2:        stl_nx = STL_W'(2);
      ADV_BR, ADV_SKIP1: stl_nx = STL_W'(1);
      default:          stl_nx = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      stall_o   <= '0;
      primed_q  <= 1'b0;
    end else begin
      next_pc_o <= pc_nx;
      taken_o   <= hit;
      stall_o   <= stl_nx;
      primed_q  <= 1'b1;
    end
  end

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == 3'd0 |->
      !taken_o && stall_o == '0 && next_pc_o == PC_W'($past(pc_i) + 1));

  p_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && !taken_o |->
      stall_o == '0 && next_pc_o == PC_W'($past(pc_i) + 1));

  p_branch_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && taken_o && ($past(op_i) == 3'd1 || $past(op_i) == 3'd2) |->
      stall_o == STL_W'(1));

  p_sign_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == 3'd1 && $past(sel_i) == 3'd4 |->
      taken_o == ($past(status_i[FLAG_N]) ^ $past(status_i[FLAG_V])));

  p_skip_eq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(op_i) == 3'd7 |-> taken_o == $past(eq_i));

  p_skip_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && taken_o && $past(op_i) >= 3'd3 |->
      next_pc_o == PC_W'($past(pc_i) + 2 + $past(two_word_i)) &&
      stall_o == STL_W'(1 + $past(two_word_i)));
endmodule

// File: tb/test_bsr_resolver.sv
module test_bsr_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pc;
  logic [7:0] sr;
  logic [2:0] op, sel;
  logic [6:0] ofs;
  logic [7:0] rv, iv;
  logic       eq, tw;
  logic [9:0] npc;
  logic       tkn;
  logic [1:0] stl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bsr_resolver i_bsr_resolver (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .status_i(sr), .op_i(op),
    .sel_i(sel), .offset_i(ofs), .reg_val_i(rv), .io_val_i(iv), .eq_i(eq),
    .two_word_i(tw), .next_pc_o(npc), .taken_o(tkn), .stall_o(stl)
  );

  task automatic check(string req, logic [9:0] e_pc, logic e_t, logic [1:0] e_s);
    n_chk++;
    if (npc !== e_pc || tkn !== e_t || stl !== e_s) begin
      n_fail++;
      $display("FAIL %s: got pc=%0d t=%0b s=%0d exp pc=%0d t=%0b s=%0d",
               req, npc, tkn, stl, e_pc, e_t, e_s);
    end
  endtask

  // independent model
  task automatic expect_of(output logic [9:0] e_pc, output logic e_t, output logic [1:0] e_s);
    logic f;
    int   k;
    f = (sel == 3'd4) ? (sr[2] ^ sr[3]) : sr[sel];
    case (op)
      3'd1: e_t = f;
      3'd2: e_t = !f;
      3'd3: e_t = !rv[sel];
      3'd4: e_t = rv[sel];
      3'd5: e_t = !iv[sel];
      3'd6: e_t = iv[sel];
      3'd7: e_t = eq;
      default: e_t = 1'b0;
    endcase
    k = ofs[6] ? int'(ofs) - 128 : int'(ofs);
    if (!e_t) begin
      e_pc = 10'((int'(pc) + 1) % 1024); e_s = 2'd0;
    end else if (op <= 3'd2) begin
      e_pc = 10'((int'(pc) + 1 + k + 1024) % 1024); e_s = 2'd1;
    end else begin
      e_pc = 10'((int'(pc) + 2 + int'(tw)) % 1024); e_s = tw ? 2'd2 : 2'd1;
    end
  endtask

  task automatic apply(string req);
    logic [9:0] e_pc; logic e_t; logic [1:0] e_s;
    expect_of(e_pc, e_t, e_s);
    @(negedge clk);
    check(req, e_pc, e_t, e_s);
  endtask

  task automatic set_in(logic [2:0] o, logic [2:0] s, logic [7:0] st, logic [9:0] p,
                        logic [6:0] k, logic [7:0] r, logic [7:0] i, logic e, logic w);
    op = o; sel = s; sr = st; pc = p; ofs = k; rv = r; iv = i; eq = e; tw = w;
  endtask

  initial begin
    set_in(3'd0, 3'd0, 8'h00, 10'd5, 7'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    #23;
    check("R12", 10'd0, 1'b0, 2'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5: wrap forward and backward
    set_in(3'd1, 3'd1, 8'h02, 10'd1020, 7'd10, 8'h00, 8'h00, 1'b0, 1'b0); apply("R5");
    set_in(3'd2, 3'd0, 8'h00, 10'd3, 7'h40, 8'h00, 8'h00, 1'b0, 1'b1);    apply("R5");
    // R4: stored S bit disagrees with N^V
    set_in(3'd1, 3'd4, 8'h10, 10'd100, 7'd4, 8'h00, 8'h00, 1'b0, 1'b0);  apply("R4");
    set_in(3'd2, 3'd4, 8'h04, 10'd100, 7'd4, 8'h00, 8'h00, 1'b0, 1'b0);  apply("R4");
    // R2: interrupt-enable bit
    set_in(3'd1, 3'd7, 8'h80, 10'd200, 7'h7f, 8'h00, 8'h00, 1'b0, 1'b0); apply("R2");
    // R10: two-word skip, R11: two-word flag on a branch
    set_in(3'd7, 3'd0, 8'h00, 10'd1022, 7'd0, 8'h00, 8'h00, 1'b1, 1'b1); apply("R10");
    set_in(3'd4, 3'd5, 8'h00, 10'd50, 7'd0, 8'h20, 8'h00, 1'b0, 1'b0);   apply("R10");
    set_in(3'd1, 3'd0, 8'h01, 10'd60, 7'd3, 8'h00, 8'h00, 1'b0, 1'b1);   apply("R11");
    set_in(3'd0, 3'd0, 8'hff, 10'd1023, 7'd3, 8'hff, 8'hff, 1'b1, 1'b1); apply("R11");

    // sweep: every class, selector and status byte
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 8; s++) begin
        for (int st = 0; st < 256; st++) begin
          int c;
          string tag;
          c = (o * 8 + s) * 256 + st;
          set_in(3'(o), 3'(s), 8'(st), 10'(c * 37), 7'(c * 5),
                 8'((c * 3) ^ st), 8'(~st ^ c), c[0], c[1]);
          case (o)
            0: tag = "R1";
            1: tag = "R2";
            2: tag = "R3";
            3, 4: tag = "R7";
            5, 6: tag = "R8";
            default: tag = "R9";
          endcase
          apply(tag);
        end
      end
    end
    // R6: not-taken forms
    set_in(3'd3, 3'd2, 8'h00, 10'd9, 7'd0, 8'h04, 8'h00, 1'b0, 1'b1);  apply("R6");
    set_in(3'd7, 3'd2, 8'h00, 10'd1023, 7'd0, 8'h04, 8'h00, 1'b0, 1'b1); apply("R6");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule